// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block is the write-only serial port of a display controller. A host drives a serial clock, a serial data line, an active-low chip select and a data/command select line. The block gathers the serial bits into bytes, most significant bit first. When the last bit of a byte arrives it emits a one-cycle strobe in the core clock domain, together with the byte and a flag. The flag says whether the byte is a command or pixel data.

All four serial pins are brought into the core clock domain through one synchronizer chain of equal depth, so their relative timing is kept. Rising edges of the serial clock are then detected in the core domain. The data/command line is sampled only on the last clock of each byte. That same clock commits the byte, so the block has no separate command phase. Releasing chip select clears the bit count, and any partial byte is dropped. Serial clock activity while chip select is high does nothing.

Top module: `ser_cmd_rx`

## Requirements
- R1: While reset is asserted and directly after it, byte_vld_o, byte_o and byte_is_data_o are all 0.
- R2: Every serial pin passes through SYNC_STAGES core flops before use. A serial clock rise is seen when the synchronized clock is 1 and was 0 one core cycle earlier, with the synchronized chip select low.
- R3: Bits are taken most significant first. The first bit of a byte appears in byte_o[BYTE_W-1] and the last bit in byte_o[0].
- R4: The core clock edge that first samples the BYTE_W-th rise is edge k. byte_vld_o is then high for exactly one core cycle, starting after edge k+SYNC_STAGES.
- R5: byte_is_data_o is the data/command level sampled with the BYTE_W-th rise, where 1 means data and 0 means command. The level of that line at all other rises has no effect.
- R6: A high synchronized chip select clears the bit count. The bits of a partial byte are dropped, and the next byte starts from its first bit.
- R7: Serial clock rises while chip select is high produce no strobe and change neither byte_o nor byte_is_data_o.
- R8: While chip select stays low, each group of BYTE_W rises produces exactly one strobe carrying that group's bits.
- R9: byte_o and byte_is_data_o change only in the cycle in which byte_vld_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host, asynchronous to the core clock |
| sdi_i | input | 1 | Serial data, most significant bit first |
| csn_i | input | 1 | Chip select, active low |
| dc_i | input | 1 | Data/command select: 1 means data, 0 means command |
| byte_o | output | BYTE_W | Last completed byte |
| byte_vld_o | output | 1 | One-cycle strobe when a byte completes |
| byte_is_data_o | output | 1 | Tag of the last byte: 1 means data, 0 means command |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2, and with BYTE_W left at 8. A latency hard-wired to a two-flop chain therefore shows up as a strobe one cycle off from the model. The wider chain also delays the chip select and data/command lines by the same amount as the clock. This exercises the case where chip select rises a few core cycles after the last serial clock rise. The stimulus toggles the data/command line on bits other than the last. It also sends back-to-back bytes under one chip select, aborts a byte part way, and toggles the serial clock with chip select high.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
  typedef struct packed {
    logic sck;
    logic sdi;
    logic csn;
    logic dc;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sck: 1'b0, sdi: 1'b0, csn: 1'b1, dc: 1'b0};
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] nxt;
    if (g == 0) begin : g_first
      assign nxt = d_i;
    end else begin : g_rest
      assign nxt = st_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= RST;
      else         st_q[g] <= nxt;
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import ser_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pins_t             pins_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o,
  output logic              is_data_o,
  output logic              rise_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sck_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, byte_q;
  logic [BYTE_W-1:0] sh_nxt;
  logic              vld_q, dc_q;

  assign rise_o = pins_i.sck & ~sck_q & ~pins_i.csn;
  assign sh_nxt = {sh_q[BYTE_W-2:0], pins_i.sdi};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
      dc_q   <= 1'b0;
    end else begin
      sck_q <= pins_i.sck;
      vld_q <= 1'b0;
      if (pins_i.csn) begin
        cnt_q <= '0;
      end else if (rise_o) begin
        sh_q <= sh_nxt;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          byte_q <= sh_nxt;
          vld_q  <= 1'b1;
          dc_q   <= pins_i.dc;   // tag sampled on the committing edge only
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_o    = byte_q;
  assign vld_o     = vld_q;
  assign is_data_o = dc_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/ser_cmd_rx.sv
module ser_cmd_rx
  import ser_rx_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              csn_i,
  input  logic              dc_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              byte_is_data_o
);
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int PIN_W  = $bits(pins_t);

  pins_t             pins_raw, pins_s;
  logic [PIN_W-1:0]  pins_sync;
  logic              sck_rise;
  logic [CNT_W-1:0]  bit_cnt;

  assign pins_raw = '{sck: sck_i, sdi: sdi_i, csn: csn_i, dc: dc_i};

  // one chain for all pins keeps their mutual alignment
  ser_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST    (PINS_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_sync)
  );

  assign pins_s = pins_t'(pins_sync);

  ser_shift #(
    .BYTE_W (BYTE_W),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pins_i    (pins_s),
    .byte_o    (byte_o),
    .vld_o     (byte_vld_o),
    .is_data_o (byte_is_data_o),
    .rise_o    (sck_rise),
    .cnt_o     (bit_cnt)
  );
endmodule

// File: rtl/ser_cmd_rx_chk.sv
module ser_cmd_rx_chk
  import ser_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(BYTE_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input pins_t             pins_s,
  input logic              sck_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [BYTE_W-1:0] byte_o,
  input logic              byte_vld_o,
  input logic              byte_is_data_o
);
  // R4
  vld_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  // R5
  dc_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise && bit_cnt == CNT_W'(BYTE_W - 1)) |=> (byte_is_data_o == $past(pins_s.dc)));

  // R6
  cs_clears_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_s.csn |=> (bit_cnt == '0));

  // R7
  cs_high_no_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_s.csn |=> !byte_vld_o);

  // R9
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |-> ($stable(byte_o) && $stable(byte_is_data_o)));
endmodule

bind ser_cmd_rx ser_cmd_rx_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pins_s         (pins_s),
  .sck_rise       (sck_rise),
  .bit_cnt        (bit_cnt),
  .byte_o         (byte_o),
  .byte_vld_o     (byte_vld_o),
  .byte_is_data_o (byte_is_data_o)
);

// File: tb/sim_ser_cmd_rx.sv
module sim_ser_cmd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int S          = 3;
  localparam int BW         = 8;
  localparam int HALF       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, csn = 1'b1, dc = 1'b0;
  logic [BW-1:0] byte_o;
  logic byte_vld, byte_is_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_cmd_rx #(.BYTE_W(BW), .SYNC_STAGES(S)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi), .csn_i(csn), .dc_i(dc),
    .byte_o(byte_o), .byte_vld_o(byte_vld), .byte_is_data_o(byte_is_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model: pin history queue, {sck,sdi,csn,dc}
  logic [3:0] hist [$];
  int  m_bits = 0;
  int  m_acc = 0;
  bit  m_vld = 0;
  int  m_byte = 0;
  bit  m_dc = 0;

  task automatic hist_reset();
    hist.delete();
    for (int i = 0; i < S + 2; i++) hist.push_front(4'b0010);
  endtask

  initial hist_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      hist_reset();
      m_bits = 0; m_acc = 0; m_vld = 0; m_byte = 0; m_dc = 0;
    end else begin
      logic [3:0] cur, prv;
      hist.push_front({sck, sdi, csn, dc});
      if (hist.size() > S + 2) void'(hist.pop_back());
      cur = hist[S];
      prv = hist[S+1];
      m_vld = 0;
      if (cur[1]) m_bits = 0;
      else if (cur[3] && !prv[3]) begin
        m_acc = ((m_acc << 1) | int'(cur[2])) & 8'hFF;
        m_bits++;
        if (m_bits == BW) begin
          m_bits = 0;
          m_vld = 1;
          m_byte = m_acc;
          m_dc = cur[0];
        end
      end
    end
  end

  // per-clock comparison plus capture of strobed bytes
  int got_byte [$];
  bit got_dc [$];

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 strobe timing", byte_vld, m_vld);
      chk(m_vld ? "R3 byte value" : "R9 byte hold", byte_o, m_byte);
      chk("R5 tag", byte_is_data, m_dc);
      if (byte_vld) begin
        got_byte.push_back(int'(byte_o));
        got_dc.push_back(byte_is_data);
      end
    end
  end

  task automatic send_bits(input logic [BW-1:0] v, input int n, input logic dc_last,
                           input logic dc_other);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sck = 1'b0;
      sdi = v[BW-1-i];
      dc  = (i == BW - 1) ? dc_last : dc_other;
      repeat (HALF - 1) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sck = 1'b0;
  endtask

  task automatic cs_low();
    @(negedge clk); csn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk); sck = 1'b0; csn = 1'b1;
    repeat (S + 6) @(negedge clk);
  endtask

  task automatic expect_bytes(input string req, input int n, input int b0, input bit d0,
                              input int b1, input bit d1);
    chk(req, got_byte.size(), n);
    if (got_byte.size() >= 1 && n >= 1) begin
      chk(req, got_byte[0], b0); chk(req, got_dc[0], d0);
    end
    if (got_byte.size() >= 2 && n >= 2) begin
      chk(req, got_byte[1], b1); chk(req, got_dc[1], d1);
    end
    got_byte.delete(); got_dc.delete();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 vld in reset", byte_vld, 0);
    chk("R1 byte in reset", byte_o, 0);
    chk("R1 tag in reset", byte_is_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 vld after reset", byte_vld, 0);
    chk("R1 byte after reset", byte_o, 0);

    // R3 R5: command byte, MSB first
    cs_low();
    send_bits(8'hA5, 8, 1'b0, 1'b0);
    cs_high();
    expect_bytes("R3 single cmd byte", 1, 'hA5, 0, 0, 0);

    // R8: back-to-back bytes under one select
    cs_low();
    send_bits(8'h3C, 8, 1'b1, 1'b1);
    send_bits(8'hFF, 8, 1'b1, 1'b0);
    cs_high();
    expect_bytes("R8 back to back", 2, 'h3C, 1, 'hFF, 1);
    cs_low();
    send_bits(8'h00, 8, 1'b0, 1'b1);
    send_bits(8'h01, 8, 1'b1, 1'b0);
    cs_high();
    expect_bytes("R8 back to back 2", 2, 'h00, 0, 'h01, 1);

    // R5: tag line toggling on non-final bits has no effect
    cs_low();
    send_bits(8'h96, 8, 1'b0, 1'b1);
    cs_high();
    expect_bytes("R5 tag only last bit", 1, 'h96, 0, 0, 0);

    // R6: partial byte dropped by select release
    cs_low();
    send_bits(8'hF0, 5, 1'b1, 1'b1);
    cs_high();
    expect_bytes("R6 partial dropped", 0, 0, 0, 0, 0);
    cs_low();
    send_bits(8'h81, 8, 1'b1, 1'b0);
    cs_high();
    expect_bytes("R6 fresh byte after abort", 1, 'h81, 1, 0, 0);

    // R7: clocks with select high are ignored
    send_bits(8'h7E, 8, 1'b0, 1'b0);
    send_bits(8'h7E, 4, 1'b0, 1'b0);
    repeat (S + 4) @(negedge clk);
    expect_bytes("R7 no strobe with cs high", 0, 0, 0, 0, 0);
    chk("R7 byte kept", byte_o, 'h81);
    chk("R7 tag kept", byte_is_data, 1);
    cs_low();
    send_bits(8'h5A, 8, 1'b0, 1'b1);
    cs_high();
    expect_bytes("R7 R2 next byte clean", 1, 'h5A, 0, 0, 0);

    finish_run();
  end
endmodule